// File: doc/BRIEF.md
# Coefficient Safeload Staging Buffer

This block lets a host replace a small group of filter coefficients while the processing core keeps running. The host fills up to five staging slots. Each slot holds a target address in parameter memory and a coefficient value. The host then arms a transfer. On the next audio frame-start pulse, the block copies every filled slot into parameter memory as one group. The whole set therefore reaches the core between two frames, and a filter never runs with a mix of old and new coefficients.

The copy shares the parameter-memory port with the core. A copy write is issued only in a cycle where the core is not reading; otherwise the copy waits. Slot writes use a valid/ready handshake. `wr_ready` is held high at all times, so the host never sees back-pressure. While a transfer is armed or running, accepted slot writes are dropped. The parameter-memory write port, the arm request, the frame pulse and the status outputs are plain signals.

Top module: `coef_commit_buf`

## Requirements
- R1: After reset, `pm_we`, `pending` and `done` are 0 and all slots are empty, so a later arm and frame pulse produce no memory writes.
- R2: A handshake with `wr_slot` below 5 stores `wr_addr`/`wr_data` in that slot and marks it filled. A later write to the same slot overwrites it. `wr_ready` is always 1. A slot index of 5 or above is dropped.
- R3: `arm_req` while idle raises `pending` and clears `done`. No memory write occurs until the next `frame_start`.
- R4: On the first `frame_start` after arming, the copy writes each filled slot once, with that slot's address and data. Writes go in ascending slot index order regardless of the order the host filled the slots. Empty slots are skipped.
- R5: `pm_we` is never 1 in a cycle where `core_rd_en` is 1. The copy holds its place until the core stops reading.
- R6: When the copy finishes, `pending` falls, `done` rises and every slot becomes empty.
- R7: Slot writes made while `pending` is 1 leave the slots unchanged.
- R8: `frame_start` without an armed transfer produces no writes. `arm_req` while `pending` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host slot write valid |
| wr_ready | output | 1 | Host slot write ready (always 1) |
| wr_slot | input | 3 | Slot index |
| wr_addr | input | 12 | Target parameter-memory address |
| wr_data | input | 28 | Coefficient value |
| arm_req | input | 1 | Arm a transfer (one-cycle pulse) |
| frame_start | input | 1 | Audio frame boundary pulse |
| core_rd_en | input | 1 | Core is reading parameter memory this cycle |
| pm_we | output | 1 | Parameter-memory write enable |
| pm_addr | output | 12 | Parameter-memory write address |
| pm_data | output | 28 | Parameter-memory write data |
| pending | output | 1 | Transfer armed or in progress |
| done | output | 1 | Last transfer completed |

## Verification
The hardest case to reach is a copy that has started but has not finished. Only in that window can slot writes and a repeated arm collide with the running transfer. To get there, the stimulus holds `core_rd_en` high across the frame pulse, which freezes the copy in place. It then issues host writes and an arm request before releasing the core. A separate sequence toggles `core_rd_en` on every cycle during a full five-slot copy, so the copy stalls and resumes between slots. Each captured write is checked for order and for clashes with core reads.

// File: rtl/coef_commit_pkg.sv
package coef_commit_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_COPY  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/coef_slot_bank.sv
module coef_slot_bank #(
  parameter int NSLOT  = 5,
  parameter int AW     = 12,
  parameter int DW     = 28,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr_all,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_vld,
  output logic [NSLOT-1:0]  vld_vec
);
  logic [AW-1:0] addr_q [NSLOT];
  logic [DW-1:0] data_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        vld_vec[s] <= 1'b0;
      end else if (hit) begin
        vld_vec[s] <= 1'b1;
      end
      if (hit) begin
        addr_q[s] <= wr_addr;
        data_q[s] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_data = '0;
    rd_vld  = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (rd_idx == SLOT_W'(s)) begin
        rd_addr = addr_q[s];
        rd_data = data_q[s];
        rd_vld  = vld_vec[s];
      end
    end
  end
endmodule

// File: rtl/coef_commit_seq.sv
module coef_commit_seq
  import coef_commit_pkg::*;
#(
  parameter int NSLOT  = 5,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic              frame_start,
  input  logic              core_rd_en,
  input  logic              cur_vld,
  output logic [SLOT_W-1:0] cur_idx,
  output logic              pm_we,
  output logic              clr_all,
  output logic              idle,
  output logic              pending,
  output logic              done
);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NSLOT - 1);

  seq_state_t st_q;
  logic       step;

  // Empty slots cost one cycle each; filled slots wait for a free port.
  assign step    = (st_q == SEQ_COPY) && (!cur_vld || !core_rd_en);
  assign pm_we   = (st_q == SEQ_COPY) && cur_vld && !core_rd_en;
  assign clr_all = step && (cur_idx == LAST_IDX);
  assign idle    = (st_q == SEQ_IDLE);
  assign pending = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      cur_idx <= '0;
      done    <= 1'b0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (arm_req) begin
          st_q <= SEQ_ARMED;
          done <= 1'b0;
        end
        SEQ_ARMED: if (frame_start) begin
          st_q    <= SEQ_COPY;
          cur_idx <= '0;
        end
        SEQ_COPY: if (step) begin
          if (cur_idx == LAST_IDX) begin
            st_q <= SEQ_IDLE;
            done <= 1'b1;
          end else begin
            cur_idx <= cur_idx + 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coef_commit_buf.sv
module coef_commit_buf #(
  parameter int NSLOT  = 5,
  parameter int AW     = 12,
  parameter int DW     = 28,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              arm_req,
  input  logic              frame_start,
  input  logic              core_rd_en,
  output logic              pm_we,
  output logic [AW-1:0]     pm_addr,
  output logic [DW-1:0]     pm_data,
  output logic              pending,
  output logic              done
);
  logic              bank_wr_en;
  logic              clr_all;
  logic              cur_vld;
  logic              idle;
  logic [SLOT_W-1:0] cur_idx;
  logic [NSLOT-1:0]  vld_vec;

  assign wr_ready   = 1'b1;
  assign bank_wr_en = wr_valid && idle && (int'(wr_slot) < NSLOT);

  coef_slot_bank #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .SLOT_W(SLOT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr_en), .wr_idx(wr_slot),
    .wr_addr(wr_addr), .wr_data(wr_data), .clr_all(clr_all),
    .rd_idx(cur_idx), .rd_addr(pm_addr), .rd_data(pm_data),
    .rd_vld(cur_vld), .vld_vec(vld_vec)
  );

  coef_commit_seq #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .frame_start(frame_start),
    .core_rd_en(core_rd_en), .cur_vld(cur_vld), .cur_idx(cur_idx),
    .pm_we(pm_we), .clr_all(clr_all), .idle(idle), .pending(pending),
    .done(done)
  );
endmodule

// File: rtl/coef_commit_chk.sv
module coef_commit_chk #(
  parameter int NSLOT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rd_en,
  input logic             pm_we,
  input logic             pending,
  input logic             done,
  input logic [NSLOT-1:0] vld_vec
);
  assert_port_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> !core_rd_en);

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !pm_we);

  assert_done_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (vld_vec == '0 && !pending));

  assert_slots_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (vld_vec == $past(vld_vec) || vld_vec == '0));

  assert_fill_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $countones(vld_vec) >= $countones($past(vld_vec)));
endmodule

bind coef_commit_buf coef_commit_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rd_en(core_rd_en), .pm_we(pm_we),
  .pending(pending), .done(done), .vld_vec(vld_vec)
);

// File: tb/coef_commit_buf_bench.sv
module coef_commit_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_slot = '0;
  logic [11:0] wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic        arm_req = 1'b0;
  logic        frame_start = 1'b0;
  logic        core_rd_en = 1'b0;
  logic        pm_we;
  logic [11:0] pm_addr;
  logic [27:0] pm_data;
  logic        pending;
  logic        done;

  int checks = 0;
  int errors = 0;
  int log_n = 0;
  int clash_n = 0;
  logic [11:0] log_addr [16];
  logic [27:0] log_data [16];

  always #5 clk = ~clk;

  coef_commit_buf u_coef_commit_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_data(wr_data),
    .arm_req(arm_req), .frame_start(frame_start), .core_rd_en(core_rd_en),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_data(pm_data),
    .pending(pending), .done(done)
  );

  always @(negedge clk) begin
    if (pm_we) begin
      if (core_rd_en) clash_n++;
      if (log_n < 16) begin
        log_addr[log_n] = pm_addr;
        log_data[log_n] = pm_data;
      end
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic host_wr(input logic [2:0] s, input logic [11:0] a,
                         input logic [27:0] d);
    wr_valid = 1'b1; wr_slot = s; wr_addr = a; wr_data = d;
    tick(1);
    wr_valid = 1'b0;
  endtask

  task automatic arm();
    arm_req = 1'b1; tick(1); arm_req = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1; tick(1); frame_start = 1'b0;
  endtask

  task automatic expect_write(input int i, input logic [11:0] a,
                              input logic [27:0] d, input string tag);
    chk(log_addr[i] == a, tag, 64'(log_addr[i]), 64'(a));
    chk(log_data[i] == d, tag, 64'(log_data[i]), 64'(d));
  endtask

  task automatic t_reset();
    chk(pm_we == 1'b0, "R1 pm_we", 64'(pm_we), 0);
    chk(pending == 1'b0, "R1 pending", 64'(pending), 0);
    chk(done == 1'b0, "R1 done", 64'(done), 0);
    chk(wr_ready == 1'b1, "R2 wr_ready", 64'(wr_ready), 1);
    log_n = 0;
    arm(); frame(); tick(8);
    chk(log_n == 0, "R1 empty after reset", 64'(log_n), 0);
    chk(done == 1'b1, "R6 done empty copy", 64'(done), 1);
  endtask

  task automatic t_full_set();
    log_n = 0;
    for (int s = 4; s >= 0; s--) host_wr(3'(s), 12'h100 + 12'(s), 28'hA000000 + 28'(s * 7));
    host_wr(3'd2, 12'h2F2, 28'hBEEF123);
    arm();
    chk(pending == 1'b1, "R3 pending", 64'(pending), 1);
    chk(done == 1'b0, "R3 done cleared", 64'(done), 0);
    tick(12);
    chk(log_n == 0, "R3 wait for frame", 64'(log_n), 0);
    frame(); tick(8);
    chk(log_n == 5, "R4 write count", 64'(log_n), 5);
    for (int s = 0; s < 5; s++) begin
      if (s == 2) expect_write(s, 12'h2F2, 28'hBEEF123, "R2 overwrite");
      else expect_write(s, 12'h100 + 12'(s), 28'hA000000 + 28'(s * 7), "R4 order");
    end
    chk(pending == 1'b0, "R6 pending low", 64'(pending), 0);
    chk(done == 1'b1, "R6 done", 64'(done), 1);
    log_n = 0;
    arm(); frame(); tick(8);
    chk(log_n == 0, "R6 slots emptied", 64'(log_n), 0);
  endtask

  task automatic t_sparse();
    log_n = 0;
    host_wr(3'd3, 12'h033, 28'h0333333);
    host_wr(3'd1, 12'h011, 28'h0111111);
    arm(); frame(); tick(8);
    chk(log_n == 2, "R4 sparse count", 64'(log_n), 2);
    expect_write(0, 12'h011, 28'h0111111, "R4 slot order");
    expect_write(1, 12'h033, 28'h0333333, "R4 slot order");
  endtask

  task automatic t_stall();
    log_n = 0; clash_n = 0;
    host_wr(3'd0, 12'h0A0, 28'h00000A0);
    host_wr(3'd4, 12'h0A4, 28'h00000A4);
    arm();
    core_rd_en = 1'b1;
    frame(); tick(10);
    chk(log_n == 0, "R5 held off", 64'(log_n), 0);
    chk(pending == 1'b1, "R5 still pending", 64'(pending), 1);
    core_rd_en = 1'b0; tick(8);
    chk(log_n == 2, "R5 resumed", 64'(log_n), 2);
    expect_write(1, 12'h0A4, 28'h00000A4, "R5 data");
    log_n = 0;
    for (int s = 0; s < 5; s++) host_wr(3'(s), 12'h300 + 12'(s), 28'(s + 9));
    arm(); frame();
    for (int c = 0; c < 20; c++) begin core_rd_en = c[0]; tick(1); end
    core_rd_en = 1'b0;
    chk(log_n == 5, "R5 toggled count", 64'(log_n), 5);
    expect_write(4, 12'h304, 28'd13, "R5 toggled data");
    chk(clash_n == 0, "R5 no clash", 64'(clash_n), 0);
  endtask

  task automatic t_locked();
    log_n = 0;
    host_wr(3'd0, 12'h555, 28'h5555555);
    arm();
    host_wr(3'd0, 12'h666, 28'h6666666);
    host_wr(3'd2, 12'h777, 28'h7777777);
    core_rd_en = 1'b1;
    frame();
    host_wr(3'd3, 12'h888, 28'h8888888);
    arm();
    core_rd_en = 1'b0; tick(8);
    chk(log_n == 1, "R7 count", 64'(log_n), 1);
    expect_write(0, 12'h555, 28'h5555555, "R7 kept");
    chk(pending == 1'b0, "R8 rearm ignored", 64'(pending), 0);
    log_n = 0;
    arm(); frame(); tick(8);
    chk(log_n == 0, "R7 dropped writes", 64'(log_n), 0);
  endtask

  task automatic t_idle_frame();
    log_n = 0;
    host_wr(3'd6, 12'h066, 28'h6);
    host_wr(3'd7, 12'h077, 28'h7);
    host_wr(3'd1, 12'h0F1, 28'hF1);
    frame(); tick(8);
    chk(log_n == 0, "R8 idle frame", 64'(log_n), 0);
    chk(pending == 1'b0, "R8 idle pending", 64'(pending), 0);
    arm(); frame(); tick(8);
    chk(log_n == 1, "R2 bad index dropped", 64'(log_n), 1);
    expect_write(0, 12'h0F1, 28'hF1, "R2 good slot");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_full_set();
    t_sparse();
    t_stall();
    t_locked();
    t_idle_frame();
    finish_run();
  end
endmodule